// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a pipelined command interface in which reads and writes may follow one another on consecutive clock cycles with no idle bus cycle between them. A command (address, byte enables, chip selects, read/write choice) is captured at a clock edge. The data for that command occupies the data bus in the cycle that ends at the second enabled edge after it. A read drives the bus during that cycle. A write has its data sampled from the bus at the edge that closes that cycle. Because both directions use the same latency, a controller can interleave them freely.

A command can either load a fresh address or continue a burst. A continuation repeats the previous operation and selection and steps the low address bits through a wrapping block. An active-low clock enable freezes the whole pipeline. A sleep input also freezes it and releases the data bus. The contents of the array are kept in both cases. An asynchronous active-low output enable gates only the bus drivers. The bidirectional bus is split into an input, an output and a drive-enable port.

Top module: `zt_sram`

## Requirements
- R1: A read issued at enabled edge t has the word stored at its address on `dq_out` during the cycle that ends at enabled edge t+2, with `dq_oe` high in that cycle (when `oe_n` is low and `sleep` is low).
- R2: For a write issued at enabled edge t, the data is taken from `dq_in` at enabled edge t+2. A read issued one cycle after a write to the same address returns the newly written data, and writes and reads may alternate every cycle.
- R3: Byte enable `bw_n[i]` low writes data bits [9i+8:9i] (lane i, 9 bits). Lanes whose enable is high keep their previous contents.
- R4: When `adv_ld` is low, the select is taken from `ce_a_n`, `ce_b_n` (active low) and `ce_c` (active high). If any of them is inactive, the command is a no-op: nothing is written and `dq_oe` stays low in its data cycle.
- R5: When `adv_ld` is high, the command address keeps the upper address bits of the previous command and adds one, modulo 4, to its two low bits. The operation type and the select are those of the last loaded command, and `rd_wr_n`, `addr` and the chip selects are ignored.
- R6: While `cke_n` is high, a clock edge changes no state: `dq_out`, `dq_oe` and all queued commands hold as if the previous cycle were extended.
- R7: While `sleep` is high, all synchronous inputs are ignored, no state changes, the memory contents are kept, and `dq_oe` is low.
- R8: `dq_oe` is the registered read-drive flag gated combinationally by `oe_n` low. `oe_n` does not affect `dq_out` or the pipeline.
- R9: Reset (`rst_n` low) empties the pipeline, clears `dq_out` and `dq_oe`, and clears the burst select, so a continuation issued before any load is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high stalls the pipeline |
| sleep | input | 1 | Low-power hold; freezes state and releases the bus |
| addr | input | ADDR_W | Command address |
| adv_ld | input | 1 | 0 loads a new command, 1 continues the burst |
| rd_wr_n | input | 1 | 1 read, 0 write; used only on load |
| bw_n | input | LANES | Active-low per-lane write enables, given with the address |
| ce_a_n | input | 1 | Active-low chip select, sampled on load |
| ce_b_n | input | 1 | Active-low chip select, sampled on load |
| ce_c | input | 1 | Active-high chip select, sampled on load |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data bus input |
| dq_out | output | LANES*LANE_W | Read data bus output |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The commit of a write and the fetch of a read that follows it fall on the same clock edge. When both target the same address, the read must see the new lanes and the old contents of the masked lanes. The bench provokes this with back-to-back write/read pairs to one address under every byte-enable pattern, and inside random traffic where such pairs occur by chance. A reference model in the bench applies writes in issue order before it evaluates reads. The read value it expects therefore reflects the merged word. A mismatch on `dq_out` in the read's data cycle is reported. The same model also runs across stalls and sleep inserted in the middle of bursts.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   typedef enum logic {
      OP_WR = 1'b0,
      OP_RD = 1'b1
   } op_e;

   function automatic logic sel_active(input logic a_n, input logic b_n, input logic c);
      return (!a_n) && (!b_n) && c;
   endfunction

endpackage

// File: rtl/zt_sram_cmd.sv
module zt_sram_cmd
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 4,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              adv_ld,
   input  logic              rd_wr_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic              ce_a_n,
   input  logic              ce_b_n,
   input  logic              ce_c,
   output logic              cmd_valid,
   output op_e               cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [LANES-1:0]  cmd_bw_n,
   output logic [ADDR_W-1:0] last_addr
);

   logic [ADDR_W-1:0] base_q;
   op_e               op_q;
   logic              sel_q;
   logic [ADDR_W-1:0] step_addr;
   logic [BURST_W-1:0] low_nxt;

   assign low_nxt = base_q[BURST_W-1:0] + BURST_W'(1);

   generate
      if (BURST_W == ADDR_W) begin : g_full_wrap
         assign step_addr = low_nxt;
      end else begin : g_block_wrap
         assign step_addr = {base_q[ADDR_W-1:BURST_W], low_nxt};
      end
   endgenerate

   always_comb begin
      if (adv_ld) begin
         cmd_addr  = step_addr;
         cmd_op    = op_q;
         cmd_valid = sel_q;
      end else begin
         cmd_addr  = addr;
         cmd_op    = op_e'(rd_wr_n);
         cmd_valid = sel_active(ce_a_n, ce_b_n, ce_c);
      end
   end

   assign cmd_bw_n  = bw_n;
   assign last_addr = base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         op_q   <= OP_RD;
         sel_q  <= 1'b0;
      end else if (en) begin
         base_q <= cmd_addr;
         op_q   <= cmd_op;
         sel_q  <= cmd_valid;
      end
   end

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cmd_valid,
   input  op_e               cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LANES-1:0]  cmd_bw_n,
   output logic              s1_valid,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LANES-1:0]  wr_bw_n,
   output logic              drv
);

   logic [LANES-1:0]  s1_bw_n;
   logic              s2_valid;
   op_e               s2_op;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_bw_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_op    <= OP_RD;
         s1_addr  <= '0;
         s1_bw_n  <= '1;
         s2_valid <= 1'b0;
         s2_op    <= OP_RD;
         s2_addr  <= '0;
         s2_bw_n  <= '1;
         drv      <= 1'b0;
      end else if (en) begin
         s1_valid <= cmd_valid;
         s1_op    <= cmd_op;
         s1_addr  <= cmd_addr;
         s1_bw_n  <= cmd_bw_n;
         s2_valid <= s1_valid;
         s2_op    <= s1_op;
         s2_addr  <= s1_addr;
         s2_bw_n  <= s1_bw_n;
         drv      <= s1_valid && (s1_op == OP_RD);
      end
   end

   assign rd_req  = en && s1_valid && (s1_op == OP_RD);
   assign rd_addr = s1_addr;
   assign wr_req  = en && s2_valid && (s2_op == OP_WR);
   assign wr_addr = s2_addr;
   assign wr_bw_n = s2_bw_n;

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_req,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_bw_n,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic                    rd_req,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic same_addr;
   assign same_addr = (wr_addr == rd_addr);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] store [DEPTH];
         logic [LANE_W-1:0] wd;
         logic [LANE_W-1:0] rq;
         logic              hit;

         assign wd  = wr_data[g*LANE_W +: LANE_W];
         assign hit = wr_req && !wr_bw_n[g];

         always_ff @(posedge clk) begin
            if (hit) store[wr_addr] <= wd;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rq <= '0;
            end else if (rd_req) begin
               rq <= (hit && same_addr) ? wd : store[rd_addr];
            end
         end

         assign rd_data[g*LANE_W +: LANE_W] = rq;
      end
   endgenerate

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    sleep,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    adv_ld,
   input  logic                    rd_wr_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    ce_a_n,
   input  logic                    ce_b_n,
   input  logic                    ce_c,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("zt_sram: ADDR_W must be at least 1");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("zt_sram: LANES and LANE_W must be at least 1");
      end
      if (BURST_W < 1 || BURST_W > ADDR_W) begin : g_bad_burst
         $error("zt_sram: BURST_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic              en;
   logic              cmd_valid;
   op_e               cmd_op;
   logic [ADDR_W-1:0] cmd_addr;
   logic [LANES-1:0]  cmd_bw_n;
   logic [ADDR_W-1:0] last_addr;
   logic              s1_valid;
   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic              s1_rd;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [LANES-1:0]  wr_bw_n;
   logic              drv;
   logic [DATA_W-1:0] rd_data;

   assign en    = !cke_n && !sleep;
   assign s1_rd = (s1_op == OP_RD);

   zt_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .addr      (addr),
      .adv_ld    (adv_ld),
      .rd_wr_n   (rd_wr_n),
      .bw_n      (bw_n),
      .ce_a_n    (ce_a_n),
      .ce_b_n    (ce_b_n),
      .ce_c      (ce_c),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .cmd_bw_n  (cmd_bw_n),
      .last_addr (last_addr)
   );

   zt_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .cmd_bw_n  (cmd_bw_n),
      .s1_valid  (s1_valid),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .wr_req    (wr_req),
      .wr_addr   (wr_addr),
      .wr_bw_n   (wr_bw_n),
      .drv       (drv)
   );

   zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (wr_req),
      .wr_addr (wr_addr),
      .wr_bw_n (wr_bw_n),
      .wr_data (dq_in),
      .rd_req  (rd_req),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign dq_out = rd_data;
   assign dq_oe  = drv && !oe_n && !sleep;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 36,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              adv_ld,
   input logic              ce_a_n,
   input logic              ce_b_n,
   input logic              ce_c,
   input logic              sleep,
   input logic              oe_n,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out,
   input logic              s1_valid,
   input logic              s1_rd,
   input logic [ADDR_W-1:0] s1_addr,
   input logic [ADDR_W-1:0] last_addr,
   input logic              drv
);

   assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && s1_valid && s1_rd) |=> drv);

   assert_deselect_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv_ld && (ce_a_n || ce_b_n || !ce_c)) |=> !s1_valid);

   assert_burst_high_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv_ld) |=> ((s1_addr >> BURST_W) == ($past(last_addr) >> BURST_W)));

   assert_burst_low_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv_ld) |=>
         (s1_addr[BURST_W-1:0] == BURST_W'($past(last_addr[BURST_W-1:0]) + BURST_W'(1))));

   assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(dq_out) && $stable(s1_valid) && $stable(s1_addr) && $stable(drv)));

   assert_sleep_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

   assert_oe_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

endmodule

bind zt_sram zt_sram_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (LANES * LANE_W),
   .BURST_W (BURST_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .adv_ld    (adv_ld),
   .ce_a_n    (ce_a_n),
   .ce_b_n    (ce_b_n),
   .ce_c      (ce_c),
   .sleep     (sleep),
   .oe_n      (oe_n),
   .dq_oe     (dq_oe),
   .dq_out    (dq_out),
   .s1_valid  (s1_valid),
   .s1_rd     (s1_rd),
   .s1_addr   (s1_addr),
   .last_addr (last_addr),
   .drv       (drv)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke_n = 1'b0;
   logic        sleep = 1'b0;
   logic [5:0]  addr = '0;
   logic        adv_ld = 1'b0;
   logic        rd_wr_n = 1'b1;
   logic [3:0]  bw_n = '1;
   logic        ce_a_n = 1'b1;
   logic        ce_b_n = 1'b1;
   logic        ce_c = 1'b0;
   logic        oe_n = 1'b0;
   logic [35:0] dq_in = '0;
   logic [35:0] dq_out;
   logic        dq_oe;

   int tests = 0;
   int fails = 0;
   string cur_tag = "R1";

   // reference model state
   logic [35:0] mm [64];
   bit          m_sel = 0;
   bit          m_rd = 1;
   logic [5:0]  m_base = '0;
   bit          s1_v = 0, s1_rd = 0;
   logic [5:0]  s1_a = '0;
   logic [3:0]  s1_bw = '1;
   string       s1_tag = "R1";
   bit          s2_v = 0, s2_rd = 0;
   logic [5:0]  s2_a = '0;
   logic [3:0]  s2_bw = '1;
   string       s2_tag = "R1";
   logic [35:0] s2_val = '0;

   always #10 clk = ~clk;

   zt_sram u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke_n   (cke_n),
      .sleep   (sleep),
      .addr    (addr),
      .adv_ld  (adv_ld),
      .rd_wr_n (rd_wr_n),
      .bw_n    (bw_n),
      .ce_a_n  (ce_a_n),
      .ce_b_n  (ce_b_n),
      .ce_c    (ce_c),
      .oe_n    (oe_n),
      .dq_in   (dq_in),
      .dq_out  (dq_out),
      .dq_oe   (dq_oe)
   );

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   task automatic check(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] bwn);
      logic [35:0] r = old;
      for (int i = 0; i < 4; i++)
         if (!bwn[i]) r[i*9 +: 9] = nw[i*9 +: 9];
      return r;
   endfunction

   task automatic model_edge();
      logic [5:0] a;
      bit adv = adv_ld;
      if (s2_v && !s2_rd) mm[s2_a] = merge(mm[s2_a], dq_in, s2_bw);
      s2_v = s1_v; s2_rd = s1_rd; s2_a = s1_a; s2_bw = s1_bw; s2_tag = s1_tag;
      if (s1_v && s1_rd) s2_val = mm[s1_a];
      if (!adv) begin
         m_sel = !ce_a_n && !ce_b_n && ce_c;
         m_rd  = rd_wr_n;
         a     = addr;
      end else begin
         a = {m_base[5:2], 2'(m_base[1:0] + 2'd1)};
      end
      m_base = a;
      s1_v = m_sel; s1_rd = m_rd; s1_a = a; s1_bw = bw_n;
      s1_tag = adv ? "R5" : (!m_sel ? "R4" : cur_tag);
   endtask

   task automatic cycle();
      bit eo;
      string t;
      dq_in = {4'($urandom()), $urandom()};
      #1;
      eo = s2_v && s2_rd && !oe_n && !sleep;
      if (sleep) t = "R7";
      else if (s2_v && s2_rd && oe_n) t = "R8";
      else if (s2_v) t = s2_tag;
      else t = cur_tag;
      check(dq_oe === eo, t, 36'(dq_oe), 36'(eo));
      if (s2_v && s2_rd) check(dq_out === s2_val, t, dq_out, s2_val);
      @(posedge clk);
      if (!cke_n && !sleep) model_edge();
      @(negedge clk);
   endtask

   task automatic cmd(bit adv, bit rd, int a, logic [3:0] bw, bit sel);
      cke_n = 0; sleep = 0; oe_n = 0;
      adv_ld = adv; rd_wr_n = rd; addr = 6'(a); bw_n = bw;
      ce_a_n = !sel; ce_b_n = 1'b0; ce_c = 1'b1;
      cycle();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cmd(0, 1, 0, 4'hF, 0);
   endtask

   task automatic rand_cycle();
      cke_n   = ($urandom % 10) == 0;
      sleep   = ($urandom % 25) == 0;
      adv_ld  = ($urandom % 3) == 0;
      rd_wr_n = 1'($urandom);
      addr    = 6'($urandom);
      bw_n    = ($urandom % 2) ? 4'h0 : 4'($urandom);
      ce_a_n  = ($urandom % 12) == 0;
      ce_b_n  = ($urandom % 12) == 0;
      ce_c    = ($urandom % 12) != 0;
      oe_n    = ($urandom % 8) == 0;
      cycle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=hang expected=finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0147));
      for (int i = 0; i < 64; i++) mm[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(dq_oe === 1'b0, "R9", 36'(dq_oe), 36'd0);
      check(dq_out === 36'd0, "R9", dq_out, 36'd0);

      // continuation before any load must do nothing
      cur_tag = "R9";
      cmd(1, 1, 0, 4'h0, 1);
      cmd(1, 0, 0, 4'h0, 1);
      idle(3);

      // fill every word with full-lane writes
      cur_tag = "R2";
      for (int i = 0; i < 64; i++) cmd(0, 0, i, 4'h0, 1);
      idle(2);

      // alternating write/read to one address, every cycle
      for (int i = 0; i < 6; i++) begin
         cmd(0, 0, 5 + i, 4'h0, 1);
         cmd(0, 1, 5 + i, 4'h0, 1);
      end
      idle(2);

      // every byte-enable pattern, each read immediately after its write
      cur_tag = "R3";
      for (int p = 0; p < 16; p++) begin
         cmd(0, 0, 11, 4'(p), 1);
         cmd(0, 1, 11, 4'hF, 1);
      end
      idle(2);

      // bursts: read from low bits 2 wraps through 3,0,1; write burst ignores rd_wr_n/selects
      cur_tag = "R5";
      cmd(0, 1, 6, 4'hF, 1);
      for (int i = 0; i < 3; i++) cmd(1, 0, 40, 4'hF, 0);
      cmd(0, 0, 15, 4'h0, 1);
      for (int i = 0; i < 4; i++) cmd(1, 1, 3, 4'h0, 0);
      for (int i = 12; i < 16; i++) cmd(0, 1, i, 4'hF, 1);
      idle(2);

      // stall in the middle of a read/write mix
      cur_tag = "R6";
      cmd(0, 1, 20, 4'hF, 1);
      cmd(0, 0, 21, 4'h0, 1);
      cke_n = 1; for (int i = 0; i < 3; i++) cycle();
      cmd(0, 1, 21, 4'hF, 1);
      cke_n = 1; for (int i = 0; i < 2; i++) cycle();
      idle(3);

      // sleep with busy inputs
      cur_tag = "R7";
      cmd(0, 1, 30, 4'hF, 1);
      cmd(0, 0, 30, 4'h0, 1);
      sleep = 1; adv_ld = 0; rd_wr_n = 0; bw_n = 4'h0;
      for (int i = 0; i < 4; i++) begin addr = 6'(30 + i); cycle(); end
      cmd(0, 1, 30, 4'hF, 1);
      idle(3);

      // output enable high during reads
      cur_tag = "R8";
      cmd(0, 1, 2, 4'hF, 1);
      cmd(0, 1, 3, 4'hF, 1);
      oe_n = 1; cycle();
      oe_n = 1; cycle();
      idle(2);

      // deselected write leaves memory untouched
      cur_tag = "R4";
      cmd(0, 0, 25, 4'h0, 0);
      cmd(1, 0, 25, 4'h0, 1);
      cmd(0, 1, 25, 4'hF, 1);
      cmd(0, 1, 26, 4'hF, 1);
      idle(3);

      // constrained random traffic
      cur_tag = "R1";
      for (int i = 0; i < 3000; i++) rand_cycle();
      idle(4);

      summary();
      $finish;
   end

endmodule